// File: doc/BRIEF.md
# Program Fetch Strobe Sequencer

This block paces the external bus strobes of an 8-bit controller core. It divides the oscillator clock into machine cycles of twelve periods. In each cycle it drives an address-latch pulse and an active-low program read strobe. At every cycle boundary it takes in a short descriptor from the core: whether a code fetch happens in the coming cycle, the fetch address, and whether the cycle also carries an external data access. It then decides whether the fetch is served by on-chip ROM or by the external bus.

On-chip ROM covers the low 4K of code space, but only while the `rom_en` pin allows it. With `rom_en` low, every fetch leaves the chip. A data-access cycle gives up one address-latch pulse and both read-strobe pulses. This leaves the bus free for the data transfer, which another block strobes. The block also reports what the low multiplexed port should carry in each period, and whether the high port should drive the upper address byte.

All outputs come from registers and line up with the internal period counter. Period index 0 is the first oscillator period after a cycle boundary, and index 11 is the last.

Top module: `memstrobe_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks. `ale` is high in period indices 1–2 and 7–8 of every cycle without a data access, which gives two pulses per cycle at a fixed rate.
- R2: When the cycle carries a data access, `ale` is high only in periods 1–2. The pulse in periods 7–8 is dropped.
- R3: In a cycle whose fetch is routed externally and which has no data access, `psen_n` is low in periods 3–5 and 9–11 and high elsewhere. This gives two read pulses.
- R4: In a cycle with a data access, `psen_n` stays high for the whole cycle, even when the fetch is routed externally.
- R5: A fetch served by on-chip ROM never drives `psen_n` low.
- R6: With `rom_en` high, fetch addresses 0x0000–0x0FFF are internal (`ext_fetch` low), and addresses 0x1000–0xFFFF are external (`ext_fetch` high).
- R7: With `rom_en` low, every fetch is external, whatever the address.
- R8: If `cycle_start` is low at the boundary, the next cycle has no fetch and no data access. `ext_fetch`, `hi_addr_en` and the read strobe stay inactive, and `ale` gives both pulses. `data_cycle` has no effect in this case.
- R9: `lo_sel` encodes the low-port content as 2'b01 (address) while `ale` is high, 2'b10 (code byte) while `psen_n` is low, and 2'b00 (released) otherwise.
- R10: `hi_addr_en` is high for the whole cycle when its fetch is external or when it carries a data access. Otherwise it is low.
- R11: While `arst_n` is low, the outputs are `ale`=0, `psen_n`=1, `lo_sel`=2'b00, `hi_addr_en`=0 and `ext_fetch`=0.
- R12: The descriptor inputs are sampled only at the clock edge that ends period 11. Changing them during periods 0–10 does not alter the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per phase |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rom_en | input | 1 | High lets the low 4K of code space come from on-chip ROM |
| fetch_addr | input | 16 | Code fetch address for the next machine cycle |
| cycle_start | input | 1 | Next machine cycle performs a code fetch |
| data_cycle | input | 1 | Next machine cycle performs an external data access |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| lo_sel | output | 2 | Low-port content: 00 released, 01 address, 10 code byte |
| hi_addr_en | output | 1 | High port drives the upper address byte this cycle |
| ext_fetch | output | 1 | The current cycle's fetch goes to the external bus |

## Verification
The hardest condition to reach from the ports is the one in R12. It is a descriptor input that changes while a cycle is running but must not affect it. The inputs only matter at one edge in twelve, so a stimulus that always changes them between cycles never shows a design that samples too early. The driver therefore applies each cycle's descriptor half a cycle ahead. For selected items it then inverts every input early in the cycle under check, while the monitor keeps comparing every period against the descriptor latched at the boundary. Fetch addresses just below and above 0x0FFF are swept under both `rom_en` levels, together with data-access and no-fetch cycles.

// File: rtl/memstrobe_pkg.sv
package memstrobe_pkg;

  // Content of the multiplexed low port in one oscillator period
  typedef enum logic [1:0] {
    LP_IDLE = 2'b00,
    LP_ADDR = 2'b01,
    LP_CODE = 2'b10
  } lo_sel_e;

  // Per-machine-cycle descriptor captured at the cycle boundary
  typedef struct packed {
    logic fetch;   // a code fetch happens this cycle
    logic ext;     // that fetch is served by the external bus
    logic data;    // the cycle carries an external data access
  } cyc_desc_t;

endpackage

// File: rtl/memstrobe_rst_sync.sv
module memstrobe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/memstrobe_phase_ctr.sv
module memstrobe_phase_ctr #(
  parameter  int PERIODS = 12,
  localparam int W       = $clog2(PERIODS)
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         rst_n,
  input  logic         adv_en,
  output logic [W-1:0] phase_q,
  output logic [W-1:0] phase_nxt,
  output logic         wrap
);

  localparam logic [W-1:0] LAST = W'(PERIODS - 1);

  always_comb begin
    phase_nxt = phase_q;
    wrap      = 1'b0;
    if (adv_en) begin
      if (phase_q == LAST) begin
        phase_nxt = '0;
        wrap      = 1'b1;
      end else begin
        phase_nxt = phase_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= LAST;
    end else if (!rst_n) begin
      phase_q <= LAST;
    end else if (adv_en) begin
      phase_q <= phase_nxt;
    end
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && phase_q != LAST) |=> (phase_q == $past(phase_q) + W'(1)));

endmodule

// File: rtl/memstrobe_fetch_route.sv
module memstrobe_fetch_route
  import memstrobe_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] INT_LAST = ADDR_W'(16'h0FFF)
) (
  input  logic              rom_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cycle_start,
  input  logic              data_cycle,
  output cyc_desc_t         desc
);

  logic above_rom;

  always_comb begin
    above_rom  = (fetch_addr > INT_LAST);
    desc.fetch = cycle_start;
    desc.ext   = cycle_start && (!rom_en || above_rom);
    desc.data  = cycle_start && data_cycle;
  end

endmodule

// File: rtl/memstrobe_strobe_gen.sv
module memstrobe_strobe_gen
  import memstrobe_pkg::*;
#(
  parameter  int PERIODS = 12,
  localparam int W       = $clog2(PERIODS)
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         rst_n,
  input  logic [W-1:0] phase_nxt,
  input  cyc_desc_t    desc_nxt,
  output logic         ale,
  output logic         psen_n,
  output lo_sel_e      lo_sel,
  output logic         hi_addr_en,
  output logic         ext_fetch
);

  localparam int HALF = PERIODS / 2;
  localparam logic [W-1:0] ALE_A0 = W'(1);
  localparam logic [W-1:0] ALE_A1 = W'(2);
  localparam logic [W-1:0] ALE_B0 = W'(HALF + 1);
  localparam logic [W-1:0] ALE_B1 = W'(HALF + 2);
  localparam logic [W-1:0] RD_A0  = W'(3);
  localparam logic [W-1:0] RD_A1  = W'(HALF - 1);
  localparam logic [W-1:0] RD_B0  = W'(HALF + 3);
  localparam logic [W-1:0] RD_B1  = W'(PERIODS - 1);

  logic    ale_d;
  logic    psen_n_d;
  lo_sel_e lo_d;
  logic    hi_d;
  logic    ext_d;
  logic    in_ale_a;
  logic    in_ale_b;
  logic    in_rd_win;

  always_comb begin
    in_ale_a  = (phase_nxt == ALE_A0) || (phase_nxt == ALE_A1);
    in_ale_b  = (phase_nxt == ALE_B0) || (phase_nxt == ALE_B1);
    in_rd_win = ((phase_nxt >= RD_A0) && (phase_nxt <= RD_A1)) ||
                ((phase_nxt >= RD_B0) && (phase_nxt <= RD_B1));
    ale_d     = in_ale_a || (in_ale_b && !desc_nxt.data);
    psen_n_d  = !(desc_nxt.ext && !desc_nxt.data && in_rd_win);
    if (ale_d) begin
      lo_d = LP_ADDR;
    end else if (!psen_n_d) begin
      lo_d = LP_CODE;
    end else begin
      lo_d = LP_IDLE;
    end
    hi_d  = desc_nxt.ext || desc_nxt.data;
    ext_d = desc_nxt.ext;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ale        <= 1'b0;
      psen_n     <= 1'b1;
      lo_sel     <= LP_IDLE;
      hi_addr_en <= 1'b0;
      ext_fetch  <= 1'b0;
    end else if (!rst_n) begin
      ale        <= 1'b0;
      psen_n     <= 1'b1;
      lo_sel     <= LP_IDLE;
      hi_addr_en <= 1'b0;
      ext_fetch  <= 1'b0;
    end else begin
      ale        <= ale_d;
      psen_n     <= psen_n_d;
      lo_sel     <= lo_d;
      hi_addr_en <= hi_d;
      ext_fetch  <= ext_d;
    end
  end

  // R9
  lo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (lo_sel == LP_CODE));

  // R9
  lo_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (lo_sel == LP_ADDR));

  // R1
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);

endmodule

// File: rtl/memstrobe_seq.sv
module memstrobe_seq
  import memstrobe_pkg::*;
#(
  parameter int              STATES   = 6,
  parameter int              PHASES   = 2,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] INT_LAST = ADDR_W'(16'h0FFF),
  parameter int              SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              rom_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cycle_start,
  input  logic              data_cycle,
  output logic              ale,
  output logic              psen_n,
  output logic [1:0]        lo_sel,
  output logic              hi_addr_en,
  output logic              ext_fetch
);

  localparam int PERIODS = STATES * PHASES;
  localparam int W       = $clog2(PERIODS);
  localparam int HALF    = PERIODS / 2;

  logic         rst_n_i;
  logic [W-1:0] phase_q;
  logic [W-1:0] phase_nxt;
  logic         wrap;
  cyc_desc_t    route_desc;
  cyc_desc_t    desc_q;
  cyc_desc_t    desc_nxt;
  lo_sel_e      lo_sel_i;

  memstrobe_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_i)
  );

  memstrobe_phase_ctr #(.PERIODS(PERIODS)) u_phase (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_n     (rst_n_i),
    .adv_en    (1'b1),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .wrap      (wrap)
  );

  memstrobe_fetch_route #(.ADDR_W(ADDR_W), .INT_LAST(INT_LAST)) u_route (
    .rom_en      (rom_en),
    .fetch_addr  (fetch_addr),
    .cycle_start (cycle_start),
    .data_cycle  (data_cycle),
    .desc        (route_desc)
  );

  // descriptor register: loaded only on the edge that closes a machine cycle
  always_comb begin
    desc_nxt = desc_q;
    if (wrap) begin
      desc_nxt = route_desc;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      desc_q <= '0;
    end else if (!rst_n_i) begin
      desc_q <= '0;
    end else if (wrap) begin
      desc_q <= desc_nxt;
    end
  end

  memstrobe_strobe_gen #(.PERIODS(PERIODS)) u_strobe (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n      (rst_n_i),
    .phase_nxt  (phase_nxt),
    .desc_nxt   (desc_nxt),
    .ale        (ale),
    .psen_n     (psen_n),
    .lo_sel     (lo_sel_i),
    .hi_addr_en (hi_addr_en),
    .ext_fetch  (ext_fetch)
  );

  assign lo_sel = lo_sel_i;

  // R5
  psen_ext_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !psen_n |-> ext_fetch);

  // R4
  psen_data_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !psen_n |-> !desc_q.data);

  // R2
  ale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (desc_q.data && phase_q == W'(HALF + 1)) |-> !ale);

  // R10
  hi_ext_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ext_fetch |-> hi_addr_en);

  // R12
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (phase_q != '0) |-> $stable(desc_q));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(ale && !psen_n));

endmodule

// File: tb/memstrobe_seq_test.sv
module memstrobe_seq_test;

  logic        clk;
  logic        rst_n;
  logic        rom_en;
  logic [15:0] fetch_addr;
  logic        cycle_start;
  logic        data_cycle;
  logic        ale;
  logic        psen_n;
  logic [1:0]  lo_sel;
  logic        hi_addr_en;
  logic        ext_fetch;

  memstrobe_seq uut (
    .clk         (clk),
    .arst_n      (rst_n),
    .rom_en      (rom_en),
    .fetch_addr  (fetch_addr),
    .cycle_start (cycle_start),
    .data_cycle  (data_cycle),
    .ale         (ale),
    .psen_n      (psen_n),
    .lo_sel      (lo_sel),
    .hi_addr_en  (hi_addr_en),
    .ext_fetch   (ext_fetch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic  ext;
    logic  data;
    int    ale_pulses;
    int    rd_pulses;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks;
  int   fails;
  int   bp;
  bit   aligned;
  bit   finished;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: apply the descriptor for the following machine cycle
  task automatic run_item(input logic cs, input logic rom, input logic [15:0] addr,
                          input logic dc, input bit disturb, input string tag);
    exp_t e;
    e.ext        = cs && (!rom || addr > 16'h0FFF);
    e.data       = cs && dc;
    e.ale_pulses = e.data ? 1 : 2;
    e.rd_pulses  = (e.ext && !e.data) ? 2 : 0;
    e.tag        = tag;
    do @(posedge clk); while (bp != 5);
    #2;
    cycle_start = cs;
    rom_en      = rom;
    fetch_addr  = addr;
    data_cycle  = dc;
    q.push_back(e);
    if (disturb) begin
      do @(posedge clk); while (bp != 2);
      #2;
      cycle_start = ~cs;
      rom_en      = ~rom;
      fetch_addr  = ~addr;
      data_cycle  = ~dc;
    end
  endtask

  // monitor: rebuild the expected waveform per period and count pulses
  exp_t  cur;
  bit    cur_v;
  int    ale_cnt;
  int    rd_cnt;
  logic  ale_prev;
  logic  psen_prev;

  always @(negedge clk) begin
    if (!rst_n) begin
      aligned   = 1'b0;
      bp        = 99;
      cur_v     = 1'b0;
      ale_prev  = ale;
      psen_prev = psen_n;
    end else begin
      if (aligned) begin
        bp = (bp == 11) ? 0 : bp + 1;
      end else if (ale && !ale_prev) begin
        aligned = 1'b1;
        bp      = 1;
      end
      if (aligned && bp == 0) begin
        if (q.size() > 0) begin
          cur     = q.pop_front();
          cur_v   = 1'b1;
          ale_cnt = 0;
          rd_cnt  = 0;
        end else begin
          cur_v = 1'b0;
        end
      end
      if (cur_v) begin
        logic       e_ale;
        logic       e_psen_n;
        logic [1:0] e_lo;
        logic [5:0] e_vec;
        logic [5:0] a_vec;
        if (ale && !ale_prev) ale_cnt++;
        if (!psen_n && psen_prev) rd_cnt++;
        e_ale    = (bp == 1 || bp == 2) || (!cur.data && (bp == 7 || bp == 8));
        e_psen_n = !(cur.ext && !cur.data && ((bp >= 3 && bp <= 5) || (bp >= 9 && bp <= 11)));
        e_lo     = e_ale ? 2'b01 : (!e_psen_n ? 2'b10 : 2'b00);
        e_vec    = {e_ale, e_psen_n, e_lo, cur.ext || cur.data, cur.ext};
        a_vec    = {ale, psen_n, lo_sel, hi_addr_en, ext_fetch};
        check(a_vec == e_vec, {cur.tag, " waveform R1 R3 R9 R10"}, int'(a_vec), int'(e_vec));
        if (bp == 11) begin
          check(ale_cnt == cur.ale_pulses, {cur.tag, " ale count R1 R2"}, ale_cnt, cur.ale_pulses);
          check(rd_cnt == cur.rd_pulses, {cur.tag, " psen count R3 R4 R5"}, rd_cnt, cur.rd_pulses);
          cur_v = 1'b0;
        end
      end
      ale_prev  = ale;
      psen_prev = psen_n;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
    summary();
  end

  initial begin
    checks      = 0;
    fails       = 0;
    finished    = 1'b0;
    bp          = 99;
    rst_n       = 1'b0;
    rom_en      = 1'b1;
    fetch_addr  = 16'h0000;
    cycle_start = 1'b0;
    data_cycle  = 1'b0;
    repeat (4) @(negedge clk);
    // R11: reset values
    check({ale, psen_n, lo_sel, hi_addr_en, ext_fetch} == 6'b010000, "R11 reset outputs",
          int'({ale, psen_n, lo_sel, hi_addr_en, ext_fetch}), 'h10);
    // drive reset-time inputs hard to show they are ignored during reset
    cycle_start = 1'b1;
    rom_en      = 1'b0;
    @(negedge clk);
    check({ale, psen_n, lo_sel, hi_addr_en, ext_fetch} == 6'b010000, "R11 reset holds with active inputs",
          int'({ale, psen_n, lo_sel, hi_addr_en, ext_fetch}), 'h10);
    cycle_start = 1'b0;
    rom_en      = 1'b1;
    rst_n       = 1'b1;

    run_item(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R5 R6 internal low");
    run_item(1'b1, 1'b1, 16'h0FFF, 1'b0, 1'b0, "R5 R6 internal last");
    run_item(1'b1, 1'b1, 16'h1000, 1'b0, 1'b0, "R3 R6 external first");
    run_item(1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, "R3 R6 external top");
    run_item(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, "R7 rom off low");
    run_item(1'b1, 1'b0, 16'h0FFF, 1'b0, 1'b0, "R7 rom off last");
    run_item(1'b1, 1'b1, 16'h1000, 1'b1, 1'b0, "R2 R4 external with data");
    run_item(1'b1, 1'b1, 16'h0100, 1'b1, 1'b0, "R2 R10 internal with data");
    run_item(1'b1, 1'b0, 16'h0800, 1'b1, 1'b0, "R4 rom off with data");
    run_item(1'b0, 1'b0, 16'h2000, 1'b1, 1'b0, "R8 no fetch");
    run_item(1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R8 no fetch quiet");
    run_item(1'b1, 1'b1, 16'h1234, 1'b0, 1'b1, "R12 external disturbed");
    run_item(1'b1, 1'b1, 16'h0800, 1'b0, 1'b1, "R12 internal disturbed");
    run_item(1'b0, 1'b1, 16'h3000, 1'b0, 1'b1, "R12 no fetch disturbed");
    for (int a = 16'h0FF8; a <= 16'h1008; a += 4) begin
      run_item(1'b1, 1'b1, 16'(a), 1'b0, 1'b0, "R6 boundary sweep");
      run_item(1'b1, 1'b0, 16'(a), 1'b0, 1'b0, "R7 boundary sweep");
    end
    run_item(1'b1, 1'b0, 16'h4000, 1'b0, 1'b0, "R1 steady rate");
    run_item(1'b1, 1'b0, 16'h4001, 1'b0, 1'b0, "R1 steady rate");

    repeat (30) @(posedge clk);
    check(q.size() == 0, "R1 all cycles observed", q.size(), 0);
    summary();
  end

endmodule